// File: doc/BRIEF.md
# Message-signalled interrupt doorbell translator

This block sits behind a small 32-bit register bus and converts message-signalled interrupt writes into wired interrupt pulses. A device that wants to raise an interrupt writes an absolute interrupt ID into a doorbell register. The block subtracts the first ID it serves from that value. When the ID falls inside the served window, the block pulses the matching output line for one clock cycle. An ID outside the window is discarded without any side effect.

Software finds the served window by reading a type register. That register packs the first served ID and the number of lines into one word. A fixed identification register and a block of reserved identification words complete the 4 KB frame. The first served ID is `BASE_OFFSET + 32` and the line count is `NUM_LINES`. Both are elaboration parameters, and their limits are checked when the design is built: at most 128 lines, and the last served ID plus one must not exceed 1020.

Top module: `msi_line_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_rdata` is zero and every bit of `irq_pulse` is low.
- R2: A 4-byte read at offset 0x008 returns `((BASE_OFFSET + 32) << 16) | NUM_LINES`, so bits [31:16] hold the first served ID and the low bits hold the line count.
- R3: A 4-byte read at offset 0xFCC returns 0x0510_0000, with bits [27:20] holding 0x51 and all other bits zero.
- R4: A 4-byte read of any offset from 0xFD0 through 0xFFC, or of any offset that is not 0x008 or 0xFCC, returns zero.
- R5: `bus_size` gives the access width in bytes (1, 2 or 4). A read whose size is not 4 returns zero, whatever the offset.
- R6: Read data appears on `bus_rdata` in the cycle after the read strobe. In any cycle that does not follow a read strobe, `bus_rdata` is zero.
- R7: A doorbell write whose ID lies in the window from `BASE_OFFSET + 32` to `BASE_OFFSET + 31 + NUM_LINES` raises only `irq_pulse[ID - BASE_OFFSET - 32]`. The line goes high in the cycle after the write and stays high for that one cycle only.
- R8: A doorbell write with an ID below the first served ID, or at or above the first served ID plus `NUM_LINES`, raises no output.
- R9: Only `bus_wdata[9:0]` forms the interrupt ID. Bits [31:10] have no effect.
- R10: A write with size 2 or 4 to the doorbell at offset 0x040 is accepted. A write of any other size raises no output.
- R11: A write to any offset other than 0x040 raises no output and leaves every read value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the 4 KB frame |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 3 | Access width in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one line per served ID |

## Verification
The bench builds the block with `BASE_OFFSET = 100` and `NUM_LINES = 20`, so the served IDs run from 132 to 151 and the type register reads 0x0084_0014. A narrow window that does not start at the default base brings both window edges and both out-of-window neighbours (131 and 152) close together. It also lets random IDs drawn around the window hit and miss at similar rates. With these values the subtraction must use a non-zero base, so a decode that ignores the base or treats the line count as a power of two shows up in the output.

// File: rtl/msi_xlate_pkg.sv
// Package msi_xlate_pkg
// Shared offsets, constants and the read-select type for the doorbell
// translator. Assumes a 12-bit byte offset into a 4 KB frame.
package msi_xlate_pkg;

    localparam int          ADDR_W      = 12;
    localparam int          DATA_W      = 32;
    localparam int          ID_W        = 10;

    localparam logic [11:0] OFS_TYPE    = 12'h008;
    localparam logic [11:0] OFS_DOOR    = 12'h040;
    localparam logic [11:0] OFS_IDENT   = 12'hFCC;

    localparam logic [31:0] IDENT_WORD  = 32'h0510_0000;

    localparam logic [2:0]  SZ_HALF     = 3'd2;
    localparam logic [2:0]  SZ_WORD     = 3'd4;

    localparam int          LINES_MAX   = 128;
    localparam int          ID_CEILING  = 1020;
    localparam int          ID_SKEW     = 32;

    // Which word a read returns.
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_TYPE  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_ZERO  = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/msi_access_decode.sv
// Module msi_access_decode
// Turns one bus access into a read selection and a doorbell-accept flag.
// Reads count only at 4 bytes, doorbell writes only at 2 or 4 bytes.
// Assumes the strobes are single-cycle and the offset is exact, with no
// masking of the low address bits.
module msi_access_decode
    import msi_xlate_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [2:0]        size,
    output rd_sel_e           rsel,
    output logic              door_wr
);

    logic rd_ok;
    logic wr_ok;

    // Check the access width for each direction.
    always_comb begin
        rd_ok = rd && (size == SZ_WORD);
        wr_ok = wr && ((size == SZ_WORD) || (size == SZ_HALF));
    end

    // Choose the word a read returns. Reserved and undefined offsets read zero.
    always_comb begin
        if (!rd_ok) begin
            rsel = SEL_NONE;
        end else if (addr == OFS_TYPE) begin
            rsel = SEL_TYPE;
        end else if (addr == OFS_IDENT) begin
            rsel = SEL_IDENT;
        end else begin
            rsel = SEL_ZERO;
        end
    end

    // Accept a doorbell only at its own offset.
    always_comb door_wr = wr_ok && (addr == OFS_DOOR);

endmodule

// File: rtl/msi_id_translate.sv
// Module msi_id_translate
// Range-checks an absolute interrupt ID against the served window and gives
// the zero-based line index. Assumes the window fits below ID 1020, so
// 11-bit arithmetic cannot overflow.
module msi_id_translate
    import msi_xlate_pkg::*;
#(
    parameter int FIRST_ID  = 32,
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             door_wr,
    input  logic [ID_W-1:0]  id,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    localparam logic [ID_W:0] LO_ID   = (ID_W+1)'(FIRST_ID);
    localparam logic [ID_W:0] HI_EXCL = (ID_W+1)'(FIRST_ID + NUM_LINES);

    logic [ID_W:0] id_ext;

    // Extend the ID by one bit so the upper window bound can be compared.
    always_comb id_ext = {1'b0, id};

    // Accept only IDs inside [LO_ID, HI_EXCL).
    always_comb hit = door_wr && (id_ext >= LO_ID) && (id_ext < HI_EXCL);

    // Subtract the first served ID to get the line index.
    always_comb idx = IDX_W'(id_ext - LO_ID);

endmodule

// File: rtl/msi_pulse_bank.sv
// Module msi_pulse_bank
// Holds one output register per interrupt line. The selected line is high for
// one cycle after an accepted doorbell, and every line is low otherwise.
// Assumes idx is below NUM_LINES whenever hit is set.
module msi_pulse_bank #(
    parameter int NUM_LINES = 64,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LINES-1:0] pulse
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Register this line's single-cycle pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulse[g] <= 1'b0;
            end else begin
                pulse[g] <= hit && (idx == IDX_W'(g));
            end
        end
    end

endmodule

// File: rtl/msi_line_xlate.sv
// Module msi_line_xlate (top)
// A 4 KB register frame that turns doorbell writes carrying absolute
// interrupt IDs into single-cycle pulses on NUM_LINES wired outputs, and that
// reports the served window through a type register. Writes finish in one
// cycle with no back-pressure. Read data is registered and is zero in any
// cycle that does not follow a read strobe.
module msi_line_xlate
    import msi_xlate_pkg::*;
#(
    parameter int BASE_OFFSET = 0,
    parameter int NUM_LINES   = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [2:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_pulse
);

    localparam int          FIRST_ID  = BASE_OFFSET + ID_SKEW;
    localparam int          IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [31:0] TYPE_WORD = {16'(FIRST_ID), 16'(NUM_LINES)};

    // Reject parameter sets that the frame cannot serve.
    if (NUM_LINES < 1 || NUM_LINES > LINES_MAX) begin : g_bad_count
        $error("msi_line_xlate: NUM_LINES must be within 1..128");
    end
    if (BASE_OFFSET < 0 || FIRST_ID + NUM_LINES > ID_CEILING) begin : g_bad_base
        $error("msi_line_xlate: served window passes interrupt ID 1020");
    end

    rd_sel_e          rsel;
    logic             door_wr;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rd_word;
    logic             unused_wdata_hi;

    // Only the low ID_W bits carry the ID. The rest are dropped on purpose.
    always_comb unused_wdata_hi = ^bus_wdata[31:ID_W];

    msi_access_decode u_decode (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .size    (bus_size),
        .rsel    (rsel),
        .door_wr (door_wr)
    );

    msi_id_translate #(
        .FIRST_ID  (FIRST_ID),
        .NUM_LINES (NUM_LINES)
    ) u_xlate (
        .door_wr (door_wr),
        .id      (bus_wdata[ID_W-1:0]),
        .hit     (hit),
        .idx     (idx)
    );

    msi_pulse_bank #(
        .NUM_LINES (NUM_LINES)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .idx   (idx),
        .pulse (irq_pulse)
    );

    // Build the read word from the selection.
    always_comb begin
        unique case (rsel)
            SEL_TYPE:  rd_word = TYPE_WORD;
            SEL_IDENT: rd_word = IDENT_WORD;
            default:   rd_word = '0;
        endcase
    end

    // Register read data for one cycle. It is zero when no read was made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/msi_line_xlate_chk.sv
// Module msi_line_xlate_chk
// Checker bound to msi_line_xlate. It relates the port activity of one cycle
// to the outputs of the next.
module msi_line_xlate_chk #(
    parameter int BASE_OFFSET = 0,
    parameter int NUM_LINES   = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [11:0]          bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [2:0]           bus_size,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] irq_pulse
);

    localparam int          FIRST_ID  = BASE_OFFSET + 32;
    localparam logic [10:0] LO_ID     = 11'(FIRST_ID);
    localparam logic [10:0] HI_EXCL   = 11'(FIRST_ID + NUM_LINES);
    localparam logic [31:0] TYPE_WORD = {16'(FIRST_ID), 16'(NUM_LINES)};
    localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

    // R7: at most one line pulses at a time
    a_r7_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse));

    // R7: the pulsing line matches the ID written one cycle before
    a_r7_line_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pulse) |-> (irq_pulse == (ONE << ({1'b0, $past(bus_wdata[9:0])} - LO_ID))));

    // R10, R11: a pulse needs an accepted doorbell write one cycle before
    a_r10_pulse_needs_door: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pulse) |-> ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == 12'h040
                          && ($past(bus_size) == 3'd2 || $past(bus_size) == 3'd4)));

    // R8: an ID outside the window gives no pulse
    a_r8_out_of_range_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_wr) && (({1'b0, $past(bus_wdata[9:0])} < LO_ID)
                           || ({1'b0, $past(bus_wdata[9:0])} >= HI_EXCL)))
        |-> (irq_pulse == '0));

    // R6, R5: non-zero read data needs a 4-byte read strobe one cycle before
    a_r6_rdata_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata != 32'h0) |-> ($past(rst_n) && $past(bus_rd) && $past(bus_size) == 3'd4));

    // R2: a read of the type register returns the served window
    a_r2_type_word: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_rd) && $past(bus_size) == 3'd4 && $past(bus_addr) == 12'h008)
        |-> (bus_rdata == TYPE_WORD));

endmodule

bind msi_line_xlate msi_line_xlate_chk #(
    .BASE_OFFSET (BASE_OFFSET),
    .NUM_LINES   (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse)
);

// File: tb/msi_line_xlate_bench.sv
`timescale 1ns/1ps
// Bench for msi_line_xlate. Directed corner cases, then seeded random traffic.
// Expected values come from bench functions.
module msi_line_xlate_bench;

    localparam int BASE  = 100;
    localparam int NUM   = 20;
    localparam int FIRST = BASE + 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [11:0]    bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [2:0]     bus_size = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NUM-1:0] irq_pulse;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    msi_line_xlate #(.BASE_OFFSET(BASE), .NUM_LINES(NUM)) u_msi_line_xlate (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
    );

    function automatic logic [31:0] exp_read(bit rd, logic [11:0] a, logic [2:0] s);
        if (!rd || s != 3'd4) return 32'h0;
        if (a == 12'h008) return (32'(FIRST) << 16) | 32'(NUM);
        if (a == 12'hFCC) return 32'h0510_0000;
        return 32'h0;
    endfunction

    function automatic logic [NUM-1:0] exp_pulse(bit wr, logic [11:0] a, logic [2:0] s,
                                                 logic [31:0] d);
        int id;
        if (!wr || a != 12'h040 || !(s == 3'd2 || s == 3'd4)) return '0;
        id = int'(d[9:0]);
        if (id < FIRST || id >= FIRST + NUM) return '0;
        return NUM'(1) << (id - FIRST);
    endfunction

    task automatic check_out(string tag, logic [31:0] er, logic [NUM-1:0] ep);
        n_checks++;
        if (bus_rdata !== er || irq_pulse !== ep) begin
            n_fails++;
            $display("FAIL %s: rdata=%h pulse=%h expected rdata=%h pulse=%h",
                     tag, bus_rdata, irq_pulse, er, ep);
        end
    endtask

    // Drive one access at a falling edge, then check at the next falling edge.
    task automatic op(string tag, bit rd, bit wr, logic [11:0] a, logic [2:0] s,
                      logic [31:0] d);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        check_out(tag, exp_read(rd, a, s), exp_pulse(wr, a, s, d));
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    endtask

    task automatic idle(string tag);
        op(tag, 1'b0, 1'b0, 12'h000, 3'd0, 32'h0);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        report();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check_out("R1 during reset", 32'h0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset", 32'h0, '0);

        op("R2 type word", 1, 0, 12'h008, 3'd4, 0);
        idle("R6 rdata clears after read");
        op("R3 ident word", 1, 0, 12'hFCC, 3'd4, 0);
        op("R4 reserved low", 1, 0, 12'hFD0, 3'd4, 0);
        op("R4 reserved high", 1, 0, 12'hFFC, 3'd4, 0);
        op("R4 reserved mid", 1, 0, 12'hFE4, 3'd4, 0);
        op("R4 undefined 0x000", 1, 0, 12'h000, 3'd4, 0);
        op("R4 doorbell reads zero", 1, 0, 12'h040, 3'd4, 0);
        op("R4 unaligned 0x009", 1, 0, 12'h009, 3'd4, 0);
        op("R5 type size 2", 1, 0, 12'h008, 3'd2, 0);
        op("R5 ident size 1", 1, 0, 12'hFCC, 3'd1, 0);

        op("R8 id below base", 0, 1, 12'h040, 3'd4, 32'(FIRST - 1));
        op("R7 first id", 0, 1, 12'h040, 3'd4, 32'(FIRST));
        idle("R7 pulse lasts one cycle");
        op("R7 last id", 0, 1, 12'h040, 3'd4, 32'(FIRST + NUM - 1));
        op("R8 id past window", 0, 1, 12'h040, 3'd4, 32'(FIRST + NUM));
        op("R8 id zero", 0, 1, 12'h040, 3'd4, 32'd0);
        op("R8 id 1023", 0, 1, 12'h040, 3'd4, 32'd1023);
        op("R9 high bits ignored", 0, 1, 12'h040, 3'd4, 32'hABCD_0000 | 32'(FIRST + 8));
        op("R9 high bits cannot reach window", 0, 1, 12'h040, 3'd4, 32'hFFFF_FC00 | 32'd5);
        op("R10 size 2 accepted", 0, 1, 12'h040, 3'd2, 32'(FIRST + 3));
        op("R10 size 1 ignored", 0, 1, 12'h040, 3'd1, 32'(FIRST + 3));
        op("R10 size 0 ignored", 0, 1, 12'h040, 3'd0, 32'(FIRST + 3));
        op("R11 write other offset", 0, 1, 12'h044, 3'd4, 32'(FIRST + 2));
        op("R11 write type reg", 0, 1, 12'h008, 3'd4, 32'hFFFF_FFFF);
        op("R11 type unchanged", 1, 0, 12'h008, 3'd4, 0);
        op("R11 write ident reg", 0, 1, 12'hFCC, 3'd4, 32'h0);
        op("R11 ident unchanged", 1, 0, 12'hFCC, 3'd4, 0);
        op("R7 back-to-back a", 0, 1, 12'h040, 3'd4, 32'(FIRST + 4));
        op("R7 back-to-back b", 0, 1, 12'h040, 3'd4, 32'(FIRST + 5));
        idle("R7 back-to-back end");

        for (int i = 0; i < 2000; i++) begin
            logic [11:0] a;
            logic [2:0]  s;
            logic [31:0] d;
            bit          rd;
            bit          wr;
            case ($urandom_range(0, 4))
                0: a = 12'h008;
                1, 2: a = 12'h040;
                3: a = 12'hFCC;
                default: a = 12'($urandom);
            endcase
            s  = 3'($urandom_range(0, 7));
            rd = bit'($urandom_range(0, 1));
            wr = bit'($urandom_range(0, 1));
            d  = {22'($urandom), 10'(FIRST - 6 + $urandom_range(0, NUM + 11))};
            if (rd && !wr) op("R2/R5/R6 random read", rd, wr, a, s, d);
            else op("R7/R8/R10 random access", rd, wr, a, s, d);
        end

        report();
    end

endmodule